// File: doc/BRIEF.md
# Compare-Capture General Purpose Timer

An up-counting timer with a small word-addressed register interface. A programmable prescaler paces the counter. Three compare channels raise flags when the count matches them, and the first of them can also set the counting period. Two capture channels latch the count when a chosen edge is seen on their input pins. The status flags are combined with per-flag enables into one interrupt line. Software drives the timer only through register writes: enable, enable mode, free-run or restart counting, and a self-clearing software reset.

The control logic is a three-state machine. The states are HALTED (prescaler held at zero, count frozen), COUNTING (prescaler and counter advance) and SWRESET (a one-cycle wipe). The named transitions are START (HALTED to COUNTING on a control write with the enable bit set), STOP (COUNTING to HALTED on a control write with the enable bit clear), WIPE (HALTED or COUNTING to SWRESET on a control write with bit 15 set) and RECOVER (SWRESET to HALTED, always, after one cycle).

Top module: `cmpcap_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is low and the state is HALTED. Register word addresses are: 0 control, 1 prescale, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture 1/2, 9 count. Unmapped addresses read zero.
- R2: While enabled (control bit 0), the count advances exactly once every P+1 clock cycles, where P is the prescale register. In HALTED the count holds and the prescaler sits at zero.
- R3: Control bit 1 is the enable mode. A START with bit 1 set clears the count and the prescaler. A START with bit 1 clear resumes from the held count.
- R4: With control bit 9 set (free-run), the count wraps from all ones to zero and sets status bit 5.
- R5: With control bit 9 clear (restart), a tick taken while the count equals compare 1 returns the count to zero and sets status bit 0. The period is therefore compare1+1 ticks.
- R6: A tick taken while the count equals compare 2 or compare 3 sets status bit 1 or 2, and the count carries on.
- R7: Status flags are write-1-to-clear at address 2. `irq` is high exactly when some status bit among 0, 1, 2 and 5 is set together with the interrupt-enable bit at the same position.
- R8: Capture mode fields sit at control bits 17:16 (channel 1) and 19:18 (channel 2). 00 is off, 01 captures on a rising edge, 10 on a falling edge, 11 on both. On a selected edge the count is latched into the capture register. A pin change sampled after edge k is latched at edge k+2 with the count held after edge k+1.
- R9: A control write with bit 15 set (WIPE) zeroes every other register. Control reads 0x8000 for one cycle. In the next cycle (SWRESET, in which bus writes are ignored) control returns to zero and the state to HALTED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| cap_pin | input | 2 | Capture inputs, channel 1 at bit 0 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each capture pin holds a level for at least two clocks, so that every edge the synchroniser sees is a real one. They also assume that no register other than control is written in the same cycle as a software reset. The bench therefore changes the pins only at falling clock edges and holds each level for several cycles. It issues exactly one bus write per cycle, always to a mapped address. It never changes the prescale or compare values while the timer is counting, so the expected counts can be worked out as plain quotients and remainders of elapsed cycles.

// File: rtl/cmpcap_pkg.sv
package cmpcap_pkg;

    typedef enum logic [1:0] {
        ST_HALTED   = 2'd0,
        ST_COUNTING = 2'd1,
        ST_SWRESET  = 2'd2
    } tmr_state_t;

    localparam logic [3:0] A_CTRL  = 4'd0;
    localparam logic [3:0] A_PRE   = 4'd1;
    localparam logic [3:0] A_STAT  = 4'd2;
    localparam logic [3:0] A_IEN   = 4'd3;
    localparam logic [3:0] A_CMP0  = 4'd4;
    localparam logic [3:0] A_CAP0  = 4'd7;
    localparam logic [3:0] A_COUNT = 4'd9;

    localparam int CB_EN      = 0;
    localparam int CB_ENMODE  = 1;
    localparam int CB_FREERUN = 9;
    localparam int CB_SWRESET = 15;
    localparam int CB_CAPMODE = 16;

    localparam int N_CMP  = 3;
    localparam int N_CAP  = 2;
    localparam int FLAG_W = 6;
    localparam logic [FLAG_W-1:0] FLAG_MASK = 6'b100111;

endpackage

// File: rtl/cmpcap_prescaler.sv
module cmpcap_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt_q;

    assign tick = run && !clear && (pcnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     pcnt_q <= '0;
        else if (clear || !run)         pcnt_q <= '0;
        else if (pcnt_q >= div)         pcnt_q <= '0;
        else                            pcnt_q <= pcnt_q + 1'b1;
    end

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcnt_q == '0)); // R2

endmodule

// File: rtl/cmpcap_capture.sv
module cmpcap_capture #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             pin,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] value
);
    logic sync_q, prev_q;
    logic rise, fall, hit;

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;
    assign hit  = (mode[0] & rise) | (mode[1] & fall);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= pin;
            prev_q <= sync_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      value <= '0;
        else if (clear)  value <= '0;
        else if (hit)    value <= count;
    end

    AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clear) |=> (value == $past(count))); // R8

endmodule

// File: rtl/cmpcap_timer.sv
module cmpcap_timer
    import cmpcap_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  cap_pin,
    output logic        irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    tmr_state_t state_q, state_d;

    logic [31:0]       ctrl_q;
    logic [PRE_W-1:0]  pre_q;
    logic [FLAG_W-1:0] stat_q, ien_q, stat_set;
    logic [CNT_W-1:0]  cmp_q [N_CMP];
    logic [CNT_W-1:0]  cap_v [N_CAP];
    logic [CNT_W-1:0]  count_q;
    logic [N_CMP-1:0]  cmp_hit;

    logic bus_open, ctrl_wr, swr_req, start_clear, wipe, run, tick, restart, roll;

    assign bus_open    = (state_q != ST_SWRESET) && bus_we;
    assign ctrl_wr     = bus_open && (bus_addr == A_CTRL);
    assign swr_req     = ctrl_wr && bus_wdata[CB_SWRESET];
    assign start_clear = (state_q == ST_HALTED) && ctrl_wr && !swr_req
                         && bus_wdata[CB_EN] && bus_wdata[CB_ENMODE];
    assign wipe        = swr_req || (state_q == ST_SWRESET);
    assign run         = (state_q == ST_COUNTING);
    assign restart     = !ctrl_q[CB_FREERUN];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    // next state: START, STOP, WIPE, RECOVER
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED: begin
                if (swr_req)                        state_d = ST_SWRESET;
                else if (ctrl_wr && bus_wdata[CB_EN]) state_d = ST_COUNTING;
            end
            ST_COUNTING: begin
                if (swr_req)                         state_d = ST_SWRESET;
                else if (ctrl_wr && !bus_wdata[CB_EN]) state_d = ST_HALTED;
            end
            ST_SWRESET: state_d = ST_HALTED;
            default:    state_d = ST_HALTED;
        endcase
    end

    cmpcap_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (start_clear || wipe),
        .div   (pre_q),
        .tick  (tick)
    );

    genvar g;
    generate
        for (g = 0; g < N_CMP; g++) begin : g_cmp
            assign cmp_hit[g] = tick && (count_q == cmp_q[g]);
        end
        for (g = 0; g < N_CAP; g++) begin : g_cap
            cmpcap_capture #(.CNT_W(CNT_W)) u_cap (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (wipe),
                .pin   (cap_pin[g]),
                .mode  (ctrl_q[CB_CAPMODE + 2*g +: 2]),
                .count (count_q),
                .value (cap_v[g])
            );
        end
    endgenerate

    assign roll     = tick && (count_q == CNT_MAX) && !(restart && cmp_hit[0]);
    assign stat_set = {roll, 2'b00, cmp_hit};

    // counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      count_q <= '0;
        else if (wipe || start_clear)    count_q <= '0;
        else if (tick) begin
            if (restart && cmp_hit[0])   count_q <= '0;
            else                         count_q <= count_q + 1'b1;
        end
    end

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pre_q  <= '0;
            stat_q <= '0;
            ien_q  <= '0;
            for (int i = 0; i < N_CMP; i++) cmp_q[i] <= '0;
        end else if (wipe) begin
            ctrl_q <= swr_req ? (32'd1 << CB_SWRESET) : 32'd0;
            pre_q  <= '0;
            stat_q <= '0;
            ien_q  <= '0;
            for (int i = 0; i < N_CMP; i++) cmp_q[i] <= '0;
        end else begin
            if (ctrl_wr)                               ctrl_q <= bus_wdata;
            if (bus_open && bus_addr == A_PRE)         pre_q  <= bus_wdata[PRE_W-1:0];
            if (bus_open && bus_addr == A_IEN)         ien_q  <= bus_wdata[FLAG_W-1:0] & FLAG_MASK;
            if (bus_open && bus_addr == A_STAT)
                stat_q <= (stat_q & ~bus_wdata[FLAG_W-1:0]) | stat_set;
            else
                stat_q <= stat_q | stat_set;
            for (int i = 0; i < N_CMP; i++)
                if (bus_open && bus_addr == A_CMP0 + 4'(i)) cmp_q[i] <= bus_wdata[CNT_W-1:0];
        end
    end

    // outputs
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:                 bus_rdata = ctrl_q;
            A_PRE:                  bus_rdata[PRE_W-1:0]  = pre_q;
            A_STAT:                 bus_rdata[FLAG_W-1:0] = stat_q;
            A_IEN:                  bus_rdata[FLAG_W-1:0] = ien_q;
            4'd4, 4'd5, 4'd6:       bus_rdata[CNT_W-1:0]  = cmp_q[bus_addr - A_CMP0];
            4'd7, 4'd8:             bus_rdata[CNT_W-1:0]  = cap_v[bus_addr - A_CAP0];
            A_COUNT:                bus_rdata[CNT_W-1:0]  = count_q;
            default:                bus_rdata = '0;
        endcase
        irq = |(stat_q & ien_q & FLAG_MASK);
    end

    AST_SWR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWRESET) |=> (state_q == ST_HALTED && ctrl_q == 32'd0)); // R9

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALTED && !ctrl_wr) |=> $stable(count_q)); // R2

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && restart && count_q == cmp_q[0] && !wipe) |=> (count_q == '0 && stat_q[0])); // R5

    AST_ROLL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && count_q == CNT_MAX && !wipe) |=> (stat_q[5] && count_q == '0)); // R4

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq); // R7

endmodule

// File: tb/cmpcap_timer_tb_top.sv
`timescale 1ns/1ps
module cmpcap_timer_tb_top;

    localparam int CW = 8;
    localparam int PW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cap_pin = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmpcap_timer #(.CNT_W(CW), .PRE_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin), .irq(irq)
    );

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0d got %h exp %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #1;
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq got %b exp %b", tag, irq, exp);
        end
    endtask

    task automatic swreset();
        wr(4'd0, 32'h8000);
        idle(1);
    endtask

    initial begin
        int e1, e2;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset values over the whole map
        for (int a = 0; a < 12; a++) chk(4'(a), 32'd0, "R1");
        chk_irq(1'b0, "R1");

        // R2: prescale sweep, pace and hold
        for (int p = 0; p < 4; p++) begin
            wr(4'd1, 32'(p));
            wr(4'd0, 32'h203);
            idle(20);
            chk(4'd9, 32'(20 / (p + 1)), "R2");
            wr(4'd0, 32'h0);
            idle(5);
            chk(4'd9, 32'(21 / (p + 1)), "R2");
        end

        // R3: enable mode resume versus clear (held count is 5)
        wr(4'd1, 32'd0);
        wr(4'd0, 32'h201);
        idle(10);
        chk(4'd9, 32'd15, "R3");
        wr(4'd0, 32'h0);
        chk(4'd9, 32'd16, "R3");
        wr(4'd0, 32'h203);
        chk(4'd9, 32'd0, "R3");
        idle(3);
        chk(4'd9, 32'd3, "R3");
        wr(4'd0, 32'h0);

        // R4/R7: free-run rollover
        for (int i = 0; i < 3; i++) wr(4'(4 + i), 32'd200);
        wr(4'd3, 32'h20);
        wr(4'd2, 32'h3F);
        chk(4'd2, 32'h0, "R7");
        wr(4'd0, 32'h203);
        idle(255);
        chk(4'd9, 32'd255, "R4");
        chk(4'd2, 32'h07, "R6");
        chk_irq(1'b0, "R7");
        idle(1);
        chk(4'd9, 32'd0, "R4");
        chk(4'd2, 32'h27, "R4");
        chk_irq(1'b1, "R7");
        wr(4'd2, 32'h20);
        chk(4'd2, 32'h07, "R7");
        chk_irq(1'b0, "R7");
        wr(4'd0, 32'h0);

        // R9: software reset
        wr(4'd0, 32'h8000);
        chk(4'd0, 32'h8000, "R9");
        chk(4'd4, 32'd0, "R9");
        chk(4'd3, 32'd0, "R9");
        idle(1);
        chk(4'd0, 32'd0, "R9");
        chk(4'd2, 32'd0, "R9");
        chk(4'd9, 32'd0, "R9");

        // R5/R6: restart mode, sweep of every cycle
        wr(4'd4, 32'd9);
        wr(4'd5, 32'd4);
        wr(4'd6, 32'd200);
        wr(4'd3, 32'h01);
        wr(4'd0, 32'h003);
        for (int n = 1; n <= 40; n++) begin
            idle(1);
            chk(4'd9, 32'(n % 10), "R5");
        end
        chk(4'd2, 32'h03, "R6");
        chk_irq(1'b1, "R7");
        wr(4'd2, 32'h01);
        chk_irq(1'b0, "R7");

        // R8: capture mode sweep, both channels
        for (int m = 0; m < 4; m++) begin
            swreset();
            wr(4'd0, 32'h203 | (32'(m) << 16) | (32'(3 - m) << 18));
            idle(10);
            cap_pin = 2'b11;
            idle(3);
            e1 = (m & 1) != 0 ? 11 : 0;
            e2 = ((3 - m) & 1) != 0 ? 11 : 0;
            chk(4'd7, 32'(e1), "R8");
            chk(4'd8, 32'(e2), "R8");
            idle(17);
            cap_pin = 2'b00;
            idle(3);
            if ((m & 2) != 0) e1 = 31;
            if (((3 - m) & 2) != 0) e2 = 31;
            chk(4'd7, 32'(e1), "R8");
            chk(4'd8, 32'(e2), "R8");
        end

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R0 watchdog got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule